// File: doc/BRIEF.md
# Five-Level Dual-Carrier Pulse Logic

This block drives the five switches of a single-phase full-bridge inverter that has an extra bidirectional switch tied to the DC-link midpoint. The bridge can then produce five output voltages: full positive, half positive, zero, half negative and full negative.

The block makes two triangular carriers that are in phase and share one period. The lower carrier covers the bottom half of the magnitude range and the upper carrier covers the top half. On every clock the unsigned reference magnitude is compared with both carriers. The result, together with a half-cycle polarity flag, picks one of the five levels. That level is decoded into registered gate commands.

The polarity flag comes from the fundamental-frequency reference generator, so the two bridge switches that follow it change only at line rate. The other three switches toggle at the carrier rate. Dead-time insertion happens downstream of this block. The carrier rate is set by the magnitude width and a clock prescaler.

Top module: `pwm5_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `gate` is 5'b00000 and `level` is 3'b000.
- R2: The lower carrier starts at 0 after reset. It rises by one per tick up to 2^(MAG_W-1)-1, then falls by one per tick down to 0, and repeats. The period is 2*(2^(MAG_W-1)-1) ticks, and with TICK_DIV=1 one tick is one clock. The upper carrier is always the lower carrier plus 2^(MAG_W-1).
- R3: The full level is selected when the magnitude is strictly greater than the upper carrier. Otherwise the half level is selected when the magnitude is strictly greater than the lower carrier. Otherwise the zero level is selected.
- R4: `level` is a two's-complement level code: +2=3'b010, +1=3'b001, 0=3'b000, -1=3'b111, -2=3'b110. The sign of a nonzero level follows `ref_neg`, where 1 means negative.
- R5: `gate` bit i drives switch S(i+1). Positive full turns on S1 and S4. Positive half turns on S4 and S5.
- R6: Negative full turns on S2 and S3. Negative half turns on S2 and S5.
- R7: The zero level turns on S3 and S4 when `ref_neg` is 0, and S1 and S2 when `ref_neg` is 1. S5 is off in both cases.
- R8: After the first cycle out of reset, exactly two gates are on in every cycle.
- R9: S4 equals the inverted polarity and S2 equals the polarity. Both change only when `ref_neg` changes. S1 and S3 are never on together.
- R10: `gate` and `level` are registered. They reflect the inputs and carrier values of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_mag | input | MAG_W | Unsigned reference magnitude, full scale 2^MAG_W-1 |
| ref_neg | input | 1 | Half-cycle polarity, 1 = negative |
| gate | output | 5 | Gate commands, bit 0 = S1 through bit 4 = S5 |
| level | output | 3 | Selected output level, signed code |

## Verification
The assertions assume that `ref_mag` and `ref_neg` are synchronous to `clk` and hold a known value after reset. Under that assumption the registered level and gates always form a legal pair. The bench drives both inputs only on falling edges, and holds them steady for whole carrier periods so that every carrier value is compared against each magnitude. It includes magnitudes at zero, at the carrier boundaries, and at full scale, where the upper peak is never exceeded. It also flips the polarity in the middle of a period.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  typedef enum logic [2:0] {
    LV_ZERO  = 3'b000,
    LV_PHALF = 3'b001,
    LV_PFULL = 3'b010,
    LV_NFULL = 3'b110,
    LV_NHALF = 3'b111
  } lvl_t;

  localparam int G_S1 = 0;
  localparam int G_S2 = 1;
  localparam int G_S3 = 2;
  localparam int G_S4 = 3;
  localparam int G_S5 = 4;
endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier #(
  parameter int MAG_W    = 8,
  parameter int TICK_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [MAG_W-2:0] car_lo,
  output logic [MAG_W-1:0] car_hi
);
  localparam int LO_W = MAG_W - 1;
  localparam logic [LO_W-1:0] LO_TOP = {LO_W{1'b1}};

  logic tick;
  logic rising;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre <= '0;
        else if (pre == PW'(TICK_DIV - 1)) pre <= '0;
        else pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_lo <= '0;
      rising <= 1'b1;
    end else if (tick) begin
      if (rising) begin
        if (car_lo == LO_TOP) begin
          car_lo <= car_lo - 1'b1;
          rising <= 1'b0;
        end else begin
          car_lo <= car_lo + 1'b1;
        end
      end else begin
        if (car_lo == '0) begin
          car_lo <= car_lo + 1'b1;
          rising <= 1'b1;
        end else begin
          car_lo <= car_lo - 1'b1;
        end
      end
    end
  end

  assign car_hi = {1'b1, car_lo};

  // R2: the triangle moves by exactly one step per tick
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (car_lo == $past(car_lo) + 1'b1) || (car_lo == $past(car_lo) - 1'b1));
endmodule

// File: rtl/pwm5_compare.sv
module pwm5_compare
  import pwm5_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic [MAG_W-1:0] mag,
  input  logic             neg,
  input  logic [MAG_W-2:0] car_lo,
  input  logic [MAG_W-1:0] car_hi,
  output lvl_t             lvl
);
  logic above_hi, above_lo;

  assign above_hi = (mag > car_hi);
  assign above_lo = (mag > {1'b0, car_lo});

  always_comb begin
    if (above_hi)      lvl = neg ? LV_NFULL : LV_PFULL;
    else if (above_lo) lvl = neg ? LV_NHALF : LV_PHALF;
    else               lvl = LV_ZERO;
  end
endmodule

// File: rtl/pwm5_gates.sv
module pwm5_gates
  import pwm5_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lvl_t       lvl,
  input  logic       neg,
  output logic [4:0] gate,
  output logic [2:0] level
);
  logic [4:0] nxt;

  always_comb begin
    nxt = '0;
    case (lvl)
      LV_PFULL: begin nxt[G_S1] = 1'b1; nxt[G_S4] = 1'b1; end
      LV_PHALF: begin nxt[G_S4] = 1'b1; nxt[G_S5] = 1'b1; end
      LV_NHALF: begin nxt[G_S2] = 1'b1; nxt[G_S5] = 1'b1; end
      LV_NFULL: begin nxt[G_S2] = 1'b1; nxt[G_S3] = 1'b1; end
      default: begin
        if (neg) begin nxt[G_S1] = 1'b1; nxt[G_S2] = 1'b1; end
        else     begin nxt[G_S3] = 1'b1; nxt[G_S4] = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate  <= '0;
      level <= LV_ZERO;
    end else begin
      gate  <= nxt;
      level <= lvl;
    end
  end

  // R9: one leg never has both devices on
  a_r9_leg_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[G_S1] && gate[G_S3]));
  // R9: line-frequency pair is complementary once running
  a_r9_line_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (gate != '0) |-> (gate[G_S2] != gate[G_S4]));
endmodule

// File: rtl/pwm5_top.sv
module pwm5_top
  import pwm5_pkg::*;
#(
  parameter int MAG_W    = 8,
  parameter int TICK_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] ref_mag,
  input  logic             ref_neg,
  output logic [4:0]       gate,
  output logic [2:0]       level
);
  logic [MAG_W-2:0] car_lo;
  logic [MAG_W-1:0] car_hi;
  lvl_t             lvl;

  pwm5_carrier #(.MAG_W(MAG_W), .TICK_DIV(TICK_DIV)) u_car (
    .clk(clk), .rst_n(rst_n), .car_lo(car_lo), .car_hi(car_hi)
  );

  pwm5_compare #(.MAG_W(MAG_W)) u_cmp (
    .mag(ref_mag), .neg(ref_neg), .car_lo(car_lo), .car_hi(car_hi), .lvl(lvl)
  );

  pwm5_gates u_gt (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .neg(ref_neg), .gate(gate), .level(level)
  );

  // R8: two devices conduct in every running cycle
  a_r8_two_on: assert property (@(posedge clk) disable iff (!rst_n)
    (gate != '0) |-> ($countones(gate) == 2));
  // R5/R6: midpoint switch on exactly for half levels
  a_r5_mid_half: assert property (@(posedge clk) disable iff (!rst_n)
    gate[G_S5] == ((level == 3'b001) || (level == 3'b111)));
  // R4: sign of a nonzero level matches the line-rate pair
  a_r4_sign_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (level != 3'b000) |-> (level[2] == gate[G_S2]));
  // R1: once running the gates never return to all-off
  a_r1_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (gate != '0) |=> (gate != '0));
endmodule

// File: tb/sim_pwm5_top.sv
module sim_pwm5_top;
  localparam int MAG_W = 8;
  localparam int HALF  = 1 << (MAG_W - 1);
  localparam int PER   = 2 * (HALF - 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [MAG_W-1:0] ref_mag = '0;
  logic             ref_neg = 1'b0;
  logic [4:0]       gate;
  logic [2:0]       level;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pwm5_top #(.MAG_W(MAG_W), .TICK_DIV(1)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_mag(ref_mag), .ref_neg(ref_neg),
    .gate(gate), .level(level)
  );

  // requirement model: triangle (R2), selection (R3), code (R4), table (R5-R7)
  int         m_lo;
  logic       m_up;
  logic [4:0] e_gate;
  logic [2:0] e_lvl;

  function automatic logic [7:0] expect_out(int mag, logic neg, int lo);
    logic [2:0] l;
    logic [4:0] g;
    if (mag > lo + HALF)      l = neg ? 3'b110 : 3'b010;
    else if (mag > lo)        l = neg ? 3'b111 : 3'b001;
    else                      l = 3'b000;
    case (l)
      3'b010: g = 5'b01001;
      3'b001: g = 5'b11000;
      3'b111: g = 5'b10010;
      3'b110: g = 5'b00110;
      default: g = neg ? 5'b00011 : 5'b01100;
    endcase
    return {l, g};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= 0; m_up <= 1'b1; e_gate <= '0; e_lvl <= '0;
    end else begin
      {e_lvl, e_gate} <= expect_out(int'(ref_mag), ref_neg, m_lo);
      if (m_up) begin
        if (m_lo == HALF - 1) begin m_lo <= m_lo - 1; m_up <= 1'b0; end
        else m_lo <= m_lo + 1;
      end else begin
        if (m_lo == 0) begin m_lo <= 1; m_up <= 1'b1; end
        else m_lo <= m_lo - 1;
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s level/gate actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R10: cycle-exact compare over n cycles
  task automatic run_cycles(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {level, gate}, {e_lvl, e_gate});
      if ($countones(gate) != 2) begin
        total++; bad++;
        $display("FAIL R8 ones actual=%0d expected=2", $countones(gate));
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_mag = 8'd200; ref_neg = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {level, gate}, 8'h00);
    rst_n = 1'b1;
    check("R1 first cycle", {level, gate}, 8'h00);
  endtask

  task automatic t_sweep(logic neg, int mag, string req);
    @(negedge clk);
    ref_neg = neg; ref_mag = mag[MAG_W-1:0];
    @(negedge clk);
    run_cycles(req, PER + 4);
  endtask

  task automatic t_polarity();
    logic s4_prev;
    ref_mag = 8'd170; ref_neg = 1'b0;
    run_cycles("R9 pos", PER / 2);
    s4_prev = gate[3];
    run_cycles("R9 pos hold", 20);
    total++;
    if (gate[3] !== s4_prev || gate[1] !== 1'b0) begin
      bad++; $display("FAIL R9 s2s4 actual=%b%b expected=01", gate[1], gate[3]);
    end
    ref_neg = 1'b1;
    @(negedge clk);
    total++;
    if (gate[1] !== 1'b1 || gate[3] !== 1'b0) begin
      bad++; $display("FAIL R9 flip actual=%b%b expected=10", gate[1], gate[3]);
    end
    run_cycles("R9 neg", PER);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_cycles("R10 early", 4);
        t_sweep(1'b0, 0,   "R7 zero pos");
        t_sweep(1'b1, 0,   "R7 zero neg");
        t_sweep(1'b0, 64,  "R3 low pos");
        t_sweep(1'b0, 128, "R5 half pos");
        t_sweep(1'b0, 129, "R2 R3 boundary");
        t_sweep(1'b0, 200, "R5 full pos");
        t_sweep(1'b0, 255, "R3 top");
        t_sweep(1'b1, 90,  "R6 half neg");
        t_sweep(1'b1, 230, "R6 full neg");
        t_sweep(1'b1, 255, "R4 code neg");
        t_polarity();
        t_reset();
        t_sweep(1'b0, 150, "R2 restart");
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule